// File: doc/BRIEF.md
# Eight-Bit Timer with Buzzer Toggle and Variable-Period PWM

This block is an up-counting timer for a small controller. A free-running prescaler, or edges on an external clock pin, advances an eight-bit count. When the count rolls over, the block raises a sticky interrupt request. The count then restarts at zero, or at a programmed reload value. A toggle output flips on every rollover, so it can drive a piezo buzzer at half the rollover rate.

In PWM mode, two mode bits pick a cycle of 256, 64, 32 or 16 counts, and the rollover moves with the chosen cycle. The reload value then acts as the duty value. It sits in two stages: software writes the first stage at any time, and the second stage, which the output compare uses, copies the first only when the count wraps to zero. A duty change written in the middle of a cycle therefore never makes a short or malformed pulse.

Software reaches the block through a synchronous bus with four word addresses. A write takes effect at the clock edge on which the write strobe is high. A read returns the addressed register combinationally, in the same cycle.

Top module: `tc8_pwm`

## Requirements
- R1: Register map: address 0 is mode, address 1 is count, address 2 is reload, address 3 holds the interrupt flag in bit 0. After reset all four read 0, and irq_o, tgl_o and pwm_o are low.
- R2: Mode bit 0 is run. With run set, PWM off (mode bit 6 = 0) and auto-reload off (mode bit 4 = 0), the count steps up by one and rolls over from 0xFF to 0x00. The rollover sets the flag, so there is one rollover every 256 counts.
- R3: With auto-reload on (mode bit 4 = 1) and PWM off, a rollover loads the count from the reload register instead of 0x00.
- R4: With the internal clock selected (mode bit 7 = 0), the 3-bit rate field r in mode bits 3:1 gives one count per 2^(8-r) cycles in which cpu_ce is high. Cycles with cpu_ce low do not advance the prescaler.
- R5: A rollover sets the flag, and irq_o follows the flag. Writing address 3 with bit 0 = 0 clears the flag. Writing bit 0 = 1 leaves the flag unchanged. If a rollover and a clearing write fall in the same cycle, the flag is set.
- R6: With PWM on, mode bits {5,4} select the cycle length: 00 gives 256 counts, 01 gives 64, 10 gives 32 and 11 gives 16. The count wraps to 0x00 at the last count of the cycle.
- R7: In PWM mode, pwm_o is high while the count is below the active duty value and low otherwise. A duty of 0 keeps the output low. A duty of at least the cycle length keeps it high for the whole cycle.
- R8: The active duty value copies the reload register only when the count wraps in PWM mode. A reload written in the middle of a cycle changes the duty from the next cycle on.
- R9: In PWM mode the flag is set once per PWM cycle, at the wrap.
- R10: With toggle enabled (mode bit 5 = 1) and PWM off, tgl_o inverts on every rollover.
- R11: With run clear, the count holds its value. A bus write to address 1 loads the count whether or not the timer runs.
- R12: With the external clock selected (mode bit 7 = 1) and run set, each rising edge of ext_clk advances the count by one, after a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ce | input | 1 | Instruction-rate enable that feeds the prescaler |
| ext_clk | input | 1 | Asynchronous external count clock |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data of the addressed register |
| irq_o | output | 1 | Overflow interrupt request |
| tgl_o | output | 1 | Toggle (buzzer) output |
| pwm_o | output | 1 | PWM output |

## Verification
The bench builds the block with its defaults: an 8-bit count, a 3-bit rate field and a two-stage synchronizer. These values keep the longest PWM cycle to 512 clocks at the fastest rate. That lets the bench measure all four cycle lengths, duties from zero to above the cycle length, and two slower prescaler rates, all by counting clocks between flag events. The small 16-count cycle makes the mid-cycle duty rewrite quick to observe in both the cycle where the write lands and the cycle that follows.

// File: rtl/tc8_pwm.sv
module tc8_pwm #(
  parameter int CNT_W       = 8,
  parameter int RATE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_ce,
  input  logic             ext_clk,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq_o,
  output logic             tgl_o,
  output logic             pwm_o
);
  localparam int MODE_W = 8;
  localparam int PRE_W  = 1 << RATE_W;
  localparam logic [CNT_W-1:0] CNT_ONES = {CNT_W{1'b1}};
  localparam logic [PRE_W-1:0] PRE_ONES = {PRE_W{1'b1}};

  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  cnt, rld_wr, rld_act, top;
  logic [PRE_W-1:0]  pre;
  logic [SYNC_STAGES:0] sync;
  logic flag, tgl_q;

  wire run     = mode_q[0];
  wire [RATE_W-1:0] rate = mode_q[RATE_W:1];
  wire aload   = mode_q[4];
  wire tgl_en  = mode_q[5];
  wire pwm_en  = mode_q[6];
  wire ext_sel = mode_q[7];

  wire mode_wr = bus_wr && bus_addr == 2'd0;
  wire cnt_wr  = bus_wr && bus_addr == 2'd1;
  wire rld_we  = bus_wr && bus_addr == 2'd2;
  wire flg_wr  = bus_wr && bus_addr == 2'd3;

  always_comb begin
    top = CNT_ONES;
    if (pwm_en)
      case ({tgl_en, aload})
        2'b00:   top = CNT_ONES;
        2'b01:   top = CNT_ONES >> 2;
        2'b10:   top = CNT_ONES >> 3;
        default: top = CNT_ONES >> 4;
      endcase
  end

  wire [PRE_W-1:0] pre_mask = PRE_ONES >> rate;
  wire int_tick = cpu_ce && ((pre & pre_mask) == pre_mask);
  wire ext_rise = sync[SYNC_STAGES-1] && !sync[SYNC_STAGES];
  wire tick     = run && (ext_sel ? ext_rise : int_tick);
  wire wrap     = tick && (cnt >= top);
  wire ov       = wrap && !cnt_wr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[SYNC_STAGES-1:0], ext_clk};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                pre <= '0;
    else if (!run || ext_sel)  pre <= '0;
    else if (cpu_ce)           pre <= pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mode_q <= '0;
    else if (mode_wr) mode_q <= bus_wdata[MODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      rld_wr <= '0;
    else if (rld_we) rld_wr <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               rld_act <= '0;
    else if (!pwm_en || ov)   rld_act <= rld_wr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt <= '0;
    else if (cnt_wr) cnt <= bus_wdata;
    else if (wrap)   cnt <= (!pwm_en && aload) ? rld_wr : '0;
    else if (tick)   cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     flag <= 1'b0;
    else if (ov)                    flag <= 1'b1;
    else if (flg_wr && !bus_wdata[0]) flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         tgl_q <= 1'b0;
    else if (ov && tgl_en && !pwm_en)   tgl_q <= ~tgl_q;

  always_comb
    case (bus_addr)
      2'd0:    bus_rdata = CNT_W'(mode_q);
      2'd1:    bus_rdata = cnt;
      2'd2:    bus_rdata = rld_wr;
      default: bus_rdata = CNT_W'(flag);
    endcase

  assign irq_o = flag;
  assign tgl_o = tgl_q;
  assign pwm_o = pwm_en && run && (cnt < rld_act);

  // R2
  normal_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov && !pwm_en && !aload) |=> (cnt == '0));
  // R3
  reload_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov && !pwm_en && aload && !rld_we) |=> (cnt == $past(rld_wr)));
  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov |=> irq_o);
  // R8
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && !ov) |=> $stable(rld_act));
  // R10
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov && tgl_en && !pwm_en) |=> (tgl_o != $past(tgl_o)));
  // R11
  frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));
  // R7
  always_comb if (rst_n) pwm_idle_chk: assert (pwm_en || !pwm_o);
endmodule

// File: tb/tc8_pwm_tb.sv
module tc8_pwm_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, cpu_ce = 1'b1, ext_clk = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic irq_o, tgl_o, pwm_o;
  int checks = 0, fails = 0, cyc = 0;

  tc8_pwm dut_i (.clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .ext_clk(ext_clk),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .tgl_o(tgl_o), .pwm_o(pwm_o));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // {psel, duty, period clocks, high clocks} at rate 7 (one count per 2 clocks)
  localparam logic [29:0] VEC [6] = '{
    {2'd0, 8'd128, 10'd512, 10'd256},
    {2'd1, 8'd16,  10'd128, 10'd32},
    {2'd2, 8'd0,   10'd64,  10'd0},
    {2'd3, 8'd20,  10'd32,  10'd32},
    {2'd1, 8'd63,  10'd128, 10'd126},
    {2'd2, 8'd200, 10'd64,  10'd64}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_flag();
    int n = 0;
    while (!irq_o && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic measure(output int per, output int hi);
    bw(2'd3, 8'd0);
    per = 1; hi = int'(pwm_o);
    while (!irq_o && per < 20000) begin
      @(negedge clk); per++; hi += int'(pwm_o);
    end
  endtask

  task automatic halt();
    bw(2'd0, 8'd0); bw(2'd3, 8'd0);
  endtask

  initial begin
    logic [7:0] d;
    int per, hi, t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(2'(a), d); chk("R1 reg", d, 0); end
    chk("R1 outputs", {irq_o, tgl_o, pwm_o}, 0);

    // R6 R7 R9 PWM table
    foreach (VEC[i]) begin
      halt();
      bw(2'd2, VEC[i][27:20]); bw(2'd1, 8'd0);
      bw(2'd0, 8'h4F | {2'b0, VEC[i][29:28], 4'b0});
      wait_flag();
      measure(per, hi);
      chk("R6 R9 period", per, int'(VEC[i][19:10]));
      chk("R7 high time", hi, int'(VEC[i][9:0]));
    end

    // R2 free rollover to zero
    halt(); bw(2'd1, 8'hFD); bw(2'd0, 8'h0F);
    wait_flag(); rd(2'd1, d); chk("R2 wrap value", d, 0);
    measure(per, hi); chk("R2 rollover period", per, 512);

    // R3 auto-reload
    halt(); bw(2'd2, 8'h40); bw(2'd1, 8'hFE); bw(2'd0, 8'h1F);
    wait_flag(); rd(2'd1, d); chk("R3 reload value", d, 8'h40);
    measure(per, hi); chk("R3 reload period", per, 384);

    // R4 prescaler rates 5 and 6
    halt(); bw(2'd1, 8'd0); bw(2'd0, 8'h0B);
    wait_flag(); measure(per, hi); chk("R4 rate5 period", per, 2048);
    halt(); bw(2'd1, 8'd0); bw(2'd0, 8'h0D);
    wait_flag(); measure(per, hi); chk("R4 rate6 period", per, 1024);

    // R4 cpu_ce low stalls
    halt(); bw(2'd1, 8'h10); cpu_ce = 1'b0; bw(2'd0, 8'h0F);
    repeat (20) @(negedge clk);
    rd(2'd1, d); chk("R4 ce stall", d, 8'h10);
    cpu_ce = 1'b1;

    // R11 stopped timer holds, write loads
    halt(); bw(2'd0, 8'h0E); bw(2'd1, 8'h33);
    repeat (30) @(negedge clk);
    rd(2'd1, d); chk("R11 frozen count", d, 8'h33);

    // R5 flag write semantics
    halt(); bw(2'd1, 8'hF0); bw(2'd0, 8'h0F); wait_flag(); bw(2'd0, 8'h00);
    bw(2'd3, 8'h01); rd(2'd3, d); chk("R5 write one keeps", d, 1);
    bw(2'd3, 8'h00); rd(2'd3, d); chk("R5 write zero clears", d, 0);

    // R10 toggle output
    halt(); bw(2'd1, 8'd0); t0 = int'(tgl_o); bw(2'd0, 8'h2F);
    wait_flag(); chk("R10 first flip", int'(tgl_o), 1 - t0);
    measure(per, hi);
    chk("R10 second flip", int'(tgl_o), t0);
    chk("R10 period", per, 512);

    // R8 double-buffered duty, 16-count cycle
    halt(); bw(2'd2, 8'd4); bw(2'd1, 8'd0); bw(2'd0, 8'h7F);
    wait_flag();
    bw(2'd3, 8'd0);
    per = 1; hi = int'(pwm_o);
    bw(2'd2, 8'd12);
    per++; hi += int'(pwm_o);
    while (!irq_o && per < 20000) begin @(negedge clk); per++; hi += int'(pwm_o); end
    chk("R8 old duty kept", hi, 8);
    measure(per, hi);
    chk("R8 new duty", hi, 24);

    // R12 external clock edges
    halt(); bw(2'd1, 8'd0); bw(2'd0, 8'h81);
    for (int e = 0; e < 5; e++) begin
      ext_clk = 1'b1; repeat (4) @(negedge clk);
      ext_clk = 1'b0; repeat (4) @(negedge clk);
    end
    rd(2'd1, d); chk("R12 ext count", d, 5);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule